// File: doc/BRIEF.md
# Pipelined Multi-Width Integer Multiplier

This block is the multiply unit of a 32-bit integer execution path. Each cycle it can take one operation: two 32-bit operands, a width select that picks 16-bit or 32-bit operands, a signedness select and a destination tag. The result leaves on the earliest port that can carry it. A 16-bit product appears on the short port. The low word of a 32-bit product comes out one cycle later on the low port. The high word of the 64-bit product follows on the high port one cycle after that.

The first pipeline register holds only partial products of 17-bit operand segments. Later stages merge them into the 32-bit low word and then into the 64-bit sum. Every output port has its own one-cycle valid pulse and its own tag copy, so results of different widths can leave in the same cycle. A synchronous flush removes every operation in flight and does not touch the stored data.

Top module: `mulx_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, every output valid, word and tag is cleared to zero.
- R2: A narrow operation (`in_wide`=0) sampled at rising edge k raises `short_valid` for exactly one cycle after edge k+1. `short_word` then carries the 32-bit product.
- R3: A wide operation (`in_wide`=1) sampled at edge k raises `low_valid` for exactly one cycle after edge k+2. `low_word` then carries bits 31:0 of the 64-bit product.
- R4: The same wide operation raises `high_valid` for exactly one cycle after edge k+3. `high_word` then carries bits 63:32 of the 64-bit product.
- R5: With `in_signed`=1 the operands are treated as two's complement numbers of the selected width. With `in_signed`=0 they are treated as unsigned.
- R6: A narrow operation uses only bits 15:0 of each operand. Bits 31:16 have no effect on its result.
- R7: Each result appears with the tag that was sampled with its operation, unchanged.
- R8: A new operation may be issued every cycle. A short result and a low or high result of different operations may be valid in the same cycle.
- R9: `flush` high at a rising edge cancels every operation in flight, and also an operation offered at that same edge, so that none of them produces a valid pulse.
- R10: Each output word and tag keeps its last value while its valid is low, including across a flush.
- R11: A narrow operation never pulses `low_valid` or `high_valid`, and a wide operation never pulses `short_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Cancels all in-flight operations |
| in_valid | input | 1 | Offers an operation this cycle |
| in_wide | input | 1 | 1: 32-bit operands, 0: 16-bit operands |
| in_signed | input | 1 | 1: signed operands, 0: unsigned |
| in_a | input | 32 | Multiplicand |
| in_b | input | 32 | Multiplier |
| in_tag | input | TAG_W | Destination tag carried with the operation |
| short_valid | output | 1 | Narrow product valid |
| short_word | output | 32 | Narrow product |
| short_tag | output | TAG_W | Tag of the narrow product |
| low_valid | output | 1 | Wide low word valid |
| low_word | output | 32 | Bits 31:0 of the wide product |
| low_tag | output | TAG_W | Tag of the low word |
| high_valid | output | 1 | Wide high word valid |
| high_word | output | 32 | Bits 63:32 of the wide product |
| high_tag | output | TAG_W | Tag of the high word |

## Verification
A wrong partial product or a wrong merge carry shows in the very next valid pulse of the affected port. It appears one edge after the first stage for narrow results, and two or three edges after it for wide results. A wrong extension shows up only for operands whose top selected bit is set, or whose unused upper half holds data, so the vectors aim at those patterns. Faults in valid or tag steering show as a pulse one cycle off, on the wrong port, or surviving a flush. Back-to-back issue with mixed widths and flushes placed at each pipeline depth exposes these within a few cycles.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int EXT_W  = WORD_W + 1;
    localparam int SEG_W  = HALF_W + 1;
    localparam int PP_W   = 2 * SEG_W;
    localparam int MID_W  = PP_W + 1;
    localparam int FULL_W = 2 * WORD_W;

    typedef logic [WORD_W-1:0]        word_t;
    typedef logic [EXT_W-1:0]         ext_t;
    typedef logic signed [PP_W-1:0]   pp_t;
    typedef logic signed [MID_W-1:0]  mid_t;
    typedef logic [FULL_W-1:0]        full_t;

    typedef enum logic {
        OPW_HALF = 1'b0,
        OPW_FULL = 1'b1
    } op_width_e;

    // four segment products: lo*lo, lo*hi, hi*lo, hi*hi
    typedef struct packed {
        pp_t ll;
        pp_t lh;
        pp_t hl;
        pp_t hh;
    } pp_set_t;

    // data carried by the wide-only second stage
    typedef struct packed {
        mid_t  mid;
        word_t ll;
        pp_t   hh;
    } wide_stage_t;

    function automatic ext_t extend_op(word_t op, op_width_e w, logic sgn);
        ext_t r;
        if (w == OPW_FULL)
            r = {sgn & op[WORD_W-1], op};
        else
            r = {{(EXT_W-HALF_W){sgn & op[HALF_W-1]}}, op[HALF_W-1:0]};
        return r;
    endfunction
endpackage

// File: rtl/mulx_extend.sv
module mulx_extend
    import mulx_pkg::*;
(
    input  word_t     op,
    input  op_width_e width,
    input  logic      sgn,
    output ext_t      ext_o
);
    assign ext_o = extend_op(op, width, sgn);

    // R6: a narrow operand's upper part is pure extension of bit 15
    always_comb begin
        if (width == OPW_HALF) begin
            p_narrow_ext_r6: assert ((~|ext_o[EXT_W-1:HALF_W]) ||
                                     (sgn && (&ext_o[EXT_W-1:HALF_W-1])))
                else $error("narrow operand extension malformed");
        end
    end
endmodule

// File: rtl/mulx_partial.sv
module mulx_partial
    import mulx_pkg::*;
(
    input  ext_t    a,
    input  ext_t    b,
    output pp_set_t pps
);
    logic signed [SEG_W-1:0] seg_a [2];
    logic signed [SEG_W-1:0] seg_b [2];
    pp_t prod [4];

    assign seg_a[0] = $signed({1'b0, a[HALF_W-1:0]});
    assign seg_a[1] = $signed(a[EXT_W-1:HALF_W]);
    assign seg_b[0] = $signed({1'b0, b[HALF_W-1:0]});
    assign seg_b[1] = $signed(b[EXT_W-1:HALF_W]);

    for (genvar g = 0; g < 4; g++) begin : g_prod
        assign prod[g] = seg_a[g / 2] * seg_b[g % 2];
    end

    assign pps.ll = prod[0];
    assign pps.lh = prod[1];
    assign pps.hl = prod[2];
    assign pps.hh = prod[3];

    // R5: the low-by-low segment product is unsigned by nature
    always_comb begin
        p_ll_nonneg_r5: assert (!pps.ll[PP_W-1])
            else $error("low segment product negative");
    end
endmodule

// File: rtl/mulx_merge.sv
module mulx_merge
    import mulx_pkg::*;
(
    input  pp_set_t pps,
    output mid_t    mid,
    output word_t   lo
);
    assign mid = {pps.lh[PP_W-1], pps.lh} + {pps.hl[PP_W-1], pps.hl};
    assign lo  = pps.ll[WORD_W-1:0] + {mid[HALF_W-1:0], {HALF_W{1'b0}}};
endmodule

// File: rtl/mulx_combine.sv
module mulx_combine
    import mulx_pkg::*;
(
    input  wide_stage_t st,
    output full_t       full
);
    localparam int MID_PAD = FULL_W - MID_W - HALF_W;

    assign full = {st.hh[WORD_W-1:0], {WORD_W{1'b0}}}
                + {{MID_PAD{st.mid[MID_W-1]}}, st.mid, {HALF_W{1'b0}}}
                + {{WORD_W{1'b0}}, st.ll};
endmodule

// File: rtl/mulx_pipe.sv
module mulx_pipe
    import mulx_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic              in_wide,
    input  logic              in_signed,
    input  logic [31:0]       in_a,
    input  logic [31:0]       in_b,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              short_valid,
    output logic [31:0]       short_word,
    output logic [TAG_W-1:0]  short_tag,
    output logic              low_valid,
    output logic [31:0]       low_word,
    output logic [TAG_W-1:0]  low_tag,
    output logic              high_valid,
    output logic [31:0]       high_word,
    output logic [TAG_W-1:0]  high_tag
);
    typedef logic [TAG_W-1:0] tag_t;

    op_width_e in_w;
    ext_t      ext_op [2];
    word_t     raw_op [2];
    pp_set_t   pps_c;

    assign in_w      = op_width_e'(in_wide);
    assign raw_op[0] = in_a;
    assign raw_op[1] = in_b;

    for (genvar i = 0; i < 2; i++) begin : g_ext
        mulx_extend u_ext (
            .op    (raw_op[i]),
            .width (in_w),
            .sgn   (in_signed),
            .ext_o (ext_op[i])
        );
    end

    mulx_partial u_partial (
        .a   (ext_op[0]),
        .b   (ext_op[1]),
        .pps (pps_c)
    );

    // stage 1: partial products only
    logic      s1_v;
    op_width_e s1_w;
    tag_t      s1_tag;
    pp_set_t   s1_pps;

    mid_t  mid_c;
    word_t lo_c;

    mulx_merge u_merge (
        .pps (s1_pps),
        .mid (mid_c),
        .lo  (lo_c)
    );

    // short port and stage 2 (wide only)
    logic        sh_v_q;
    word_t       sh_word_q;
    tag_t        sh_tag_q;
    logic        s2_v;
    tag_t        s2_tag;
    wide_stage_t s2_d;
    full_t       full_c;

    mulx_combine u_combine (
        .st   (s2_d),
        .full (full_c)
    );

    // low and high ports
    logic  lo_v_q;
    word_t lo_word_q;
    tag_t  lo_tag_q;
    word_t hi_pend_q;
    logic  hi_v_q;
    word_t hi_word_q;
    tag_t  hi_tag_q;

    logic ld_s1, ld_sh, ld_s2, ld_lo, ld_hi;
    assign ld_s1 = in_valid & ~flush;
    assign ld_sh = s1_v & (s1_w == OPW_HALF) & ~flush;
    assign ld_s2 = s1_v & (s1_w == OPW_FULL) & ~flush;
    assign ld_lo = s2_v & ~flush;
    assign ld_hi = lo_v_q & ~flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v      <= 1'b0;
            s1_w      <= OPW_HALF;
            s1_tag    <= '0;
            s1_pps    <= '0;
            sh_v_q    <= 1'b0;
            sh_word_q <= '0;
            sh_tag_q  <= '0;
            s2_v      <= 1'b0;
            s2_tag    <= '0;
            s2_d      <= '0;
            lo_v_q    <= 1'b0;
            lo_word_q <= '0;
            lo_tag_q  <= '0;
            hi_pend_q <= '0;
            hi_v_q    <= 1'b0;
            hi_word_q <= '0;
            hi_tag_q  <= '0;
        end else begin
            s1_v   <= ld_s1;
            sh_v_q <= ld_sh;
            s2_v   <= ld_s2;
            lo_v_q <= ld_lo;
            hi_v_q <= ld_hi;
            if (ld_s1) begin
                s1_w   <= in_w;
                s1_tag <= in_tag;
                s1_pps <= pps_c;
            end
            if (ld_sh) begin
                sh_word_q <= lo_c;
                sh_tag_q  <= s1_tag;
            end
            if (ld_s2) begin
                s2_tag    <= s1_tag;
                s2_d.mid  <= mid_c;
                s2_d.ll   <= s1_pps.ll[WORD_W-1:0];
                s2_d.hh   <= s1_pps.hh;
            end
            if (ld_lo) begin
                lo_word_q <= full_c[WORD_W-1:0];
                hi_pend_q <= full_c[FULL_W-1:WORD_W];
                lo_tag_q  <= s2_tag;
            end
            if (ld_hi) begin
                hi_word_q <= hi_pend_q;
                hi_tag_q  <= lo_tag_q;
            end
        end
    end

    assign short_valid = sh_v_q;
    assign short_word  = sh_word_q;
    assign short_tag   = sh_tag_q;
    assign low_valid   = lo_v_q;
    assign low_word    = lo_word_q;
    assign low_tag     = lo_tag_q;
    assign high_valid  = hi_v_q;
    assign high_word   = hi_word_q;
    assign high_tag    = hi_tag_q;

    // R2, R7: narrow result two edges after issue, tag intact
    p_short_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide && !flush) ##1 !flush |=>
            short_valid && short_tag == $past(in_tag, 2))
        else $error("narrow result missing or mis-tagged");

    // R3, R7: wide low word three edges after issue
    p_low_lat_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_wide && !flush) ##1 !flush ##1 !flush |=>
            low_valid && low_tag == $past(in_tag, 3))
        else $error("wide low word missing or mis-tagged");

    // R4: high word follows low word by one cycle
    p_high_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (low_valid && !flush) |=> high_valid && high_tag == $past(low_tag))
        else $error("high word did not follow low word");

    p_high_source_r4: assert property (@(posedge clk) disable iff (rst)
        high_valid |-> $past(low_valid))
        else $error("high word without preceding low word");

    // R9: flush leaves nothing valid
    p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !short_valid && !low_valid && !high_valid)
        else $error("valid pulse survived flush");

    // R10: words hold while their valid is low
    p_short_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!short_valid && !$past(rst)) |-> $stable(short_word) && $stable(short_tag))
        else $error("short word changed without valid");

    p_high_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!high_valid && !$past(rst)) |-> $stable(high_word) && $stable(high_tag))
        else $error("high word changed without valid");
endmodule

// File: tb/mulx_pipe_bench.sv
`timescale 1ns/1ps
module mulx_pipe_bench;
    localparam int TAG_W = 5;
    localparam int NVEC  = 12;
    localparam int HMAX  = 128;

    // {wide, signed, a, b}
    localparam logic [65:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 32'hABCD_FFFF, 32'h1234_FFFF},
        {1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 32'h5555_FFFF, 32'h5555_0002},
        {1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 32'h0000_8000, 32'hFFFF_8000},
        {1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000},
        {1'b0, 1'b1, 32'h0000_7FFF, 32'h0000_8000},
        {1'b1, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF},
        {1'b1, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
        {1'b0, 1'b0, 32'hFFFF_1234, 32'h0000_5678},
        {1'b1, 1'b1, 32'h0000_0000, 32'hDEAD_BEEF},
        {1'b1, 1'b0, 32'h0001_0000, 32'h0001_0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic in_valid = 1'b0, in_wide = 1'b0, in_signed = 1'b0;
    logic [31:0] in_a = '0, in_b = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic short_valid, low_valid, high_valid;
    logic [31:0] short_word, low_word, high_word;
    logic [TAG_W-1:0] short_tag, low_tag, high_tag;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic             hv   [HMAX];
    logic             hw   [HMAX];
    logic [63:0]      hexp [HMAX];
    logic [TAG_W-1:0] htag [HMAX];

    always #10 clk = ~clk;

    mulx_pipe #(.TAG_W(TAG_W)) u_mulx_pipe (
        .clk, .rst, .flush, .in_valid, .in_wide, .in_signed,
        .in_a, .in_b, .in_tag,
        .short_valid, .short_word, .short_tag,
        .low_valid, .low_word, .low_tag,
        .high_valid, .high_word, .high_tag
    );

    function automatic logic [63:0] ref_prod(logic w, logic s, logic [31:0] a, logic [31:0] b);
        logic [31:0] xa, xb;
        logic [63:0] ea, eb;
        xa = w ? a : (s ? {{16{a[15]}}, a[15:0]} : {16'h0, a[15:0]});
        xb = w ? b : (s ? {{16{b[15]}}, b[15:0]} : {16'h0, b[15:0]});
        ea = s ? {{32{xa[31]}}, xa} : {32'h0, xa};
        eb = s ? {{32{xb[31]}}, xb} : {32'h0, xb};
        return ea * eb;
    endfunction

    // compares the three ports against the operations recorded so far
    task automatic check_ports();
        int js, jl, jh;
        logic es, el, eh;
        js = cyc - 2; jl = cyc - 3; jh = cyc - 4;
        es = (js >= 0) && hv[js] && !hw[js];
        el = (jl >= 0) && hv[jl] && hw[jl];
        eh = (jh >= 0) && hv[jh] && hw[jh];
        // R2 R5 R6 R7 R11 short port
        checks++;
        if (short_valid !== es ||
            (es && (short_word !== hexp[js][31:0] || short_tag !== htag[js]))) begin
            fails++;
            $display("FAIL R2 short: got v=%0b w=%h t=%0d exp v=%0b w=%h t=%0d",
                short_valid, short_word, short_tag, es,
                es ? hexp[js][31:0] : 32'h0, es ? htag[js] : '0);
        end
        // R3 R5 R7 R8 R11 low port
        checks++;
        if (low_valid !== el ||
            (el && (low_word !== hexp[jl][31:0] || low_tag !== htag[jl]))) begin
            fails++;
            $display("FAIL R3 low: got v=%0b w=%h t=%0d exp v=%0b w=%h t=%0d",
                low_valid, low_word, low_tag, el,
                el ? hexp[jl][31:0] : 32'h0, el ? htag[jl] : '0);
        end
        // R4 R5 R7 high port
        checks++;
        if (high_valid !== eh ||
            (eh && (high_word !== hexp[jh][63:32] || high_tag !== htag[jh]))) begin
            fails++;
            $display("FAIL R4 high: got v=%0b w=%h t=%0d exp v=%0b w=%h t=%0d",
                high_valid, high_word, high_tag, eh,
                eh ? hexp[jh][63:32] : 32'h0, eh ? htag[jh] : '0);
        end
    endtask

    task automatic step(input logic iv, input logic w, input logic s,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [TAG_W-1:0] tg, input logic fl);
        @(negedge clk);
        check_ports();
        in_valid = iv; in_wide = w; in_signed = s;
        in_a = a; in_b = b; in_tag = tg; flush = fl;
        @(posedge clk);
        hv[cyc]   = iv && !fl;
        hw[cyc]   = w;
        hexp[cyc] = ref_prod(w, s, a, b);
        htag[cyc] = tg;
        if (fl) begin
            for (int d = 1; d <= 3; d++)
                if (cyc - d >= 0) hv[cyc - d] = 1'b0;
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0);
    endtask

    task automatic chk_word(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    initial begin
        logic [31:0] sv_s, sv_l, sv_h;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (short_valid !== 1'b0 || low_valid !== 1'b0 || high_valid !== 1'b0 ||
            short_word !== '0 || low_word !== '0 || high_word !== '0 ||
            short_tag !== '0 || low_tag !== '0 || high_tag !== '0) begin
            fails++;
            $display("FAIL R1 reset: got v=%0b%0b%0b words %h %h %h exp all zero",
                short_valid, low_valid, high_valid, short_word, low_word, high_word);
        end
        rst = 1'b0;

        // vector table, issued back to back (R8)
        for (int i = 0; i < NVEC; i++)
            step(1'b1, VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0],
                 TAG_W'(i), 1'b0);
        idle(5);

        // R10: words hold while idle
        #1;
        sv_s = short_word; sv_l = low_word; sv_h = high_word;

        // R9: flush with a wide op in stage 1 and a narrow op offered
        step(1'b1, 1'b1, 1'b0, 32'h0000_0003, 32'h0000_0005, 5'd20, 1'b0);
        step(1'b1, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_0009, 5'd21, 1'b1);
        idle(5);
        // R9: flush with a wide op two stages deep
        step(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFE, 32'h0000_0003, 5'd22, 1'b0);
        idle(1);
        step(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1);
        idle(5);
        #1;
        chk_word("R10 short hold", short_word, sv_s);
        chk_word("R10 low hold",   low_word,   sv_l);
        chk_word("R10 high hold",  high_word,  sv_h);

        // recovery after flush, mixed widths in the same cycle (R8)
        step(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFE, 32'h0000_0003, 5'd23, 1'b0);
        step(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFD, 32'h1234_0004, 5'd24, 1'b0);
        idle(5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule